// File: doc/BRIEF.md
# SDRAM Row/Column Address Multiplexer

This block converts a flat logical address into the values an SDRAM device sees on its address pins for each command. On an activate it moves the row field down onto the lowest pins. On a read or write it presents the column on the lowest pins and keeps the rest of the logical address on the bus. In every command the two bank-select bits are placed at a pin position taken from a configuration field. The logical address is laid out with the column in the low bits, the bank-select field above it, and the row in the top bits. The defaults are 9 column bits, 2 bank bits and 13 row bits.

The address and data share one set of pins. For this reason each access takes two cycles. In the address phase a latch-enable strobe is high, so an external latch can capture the 24-bit address bus. In the following data phase the bus is released to data and is driven as zero. The three lowest device address bits do not pass through the latch. They leave on a dedicated output and are held through both phases. Device pin A10 also has its own output, which is held through both phases. It carries row bit 10 on an activate, and the control flag on every other command.

The configuration is read only when a command is accepted in the idle state. Changes made during an access therefore have no effect on that access.

Top module: `sdram_amux`

## Requirements
- R1: During reset and in the cycle that follows it, `busy`, `ale`, `addr_bus`, `sda10` and `burst_lo` are all zero.
- R2: When `cmd_valid` is high while `busy` is low, the command is accepted at that clock edge. In the next cycle `ale` and `busy` are both high. In the cycle after that, `ale` is low and `busy` is still high. In the third cycle `busy` is low again.
- R3: A `cmd_valid` that arrives while `busy` is high is ignored, and it does not lengthen the access.
- R4: For an activate (`cmd_kind` = 2'b00), the address phase drives `addr_bus[12:0]` with the row, `log_addr[23:11]`. The bank bits `log_addr[10:9]` go to `addr_bus[q+1:q]`, where q is the effective bank position. All other bits are zero.
- R5: For an activate, `sda10` equals row bit 10, `log_addr[21]`, and `burst_lo` equals the low row bits `log_addr[13:11]`.
- R6: For a read (2'b01) or a write (2'b10), the address phase drives `addr_bus` with `log_addr`, except that `addr_bus[q+1:q]` is replaced by the bank bits `log_addr[10:9]`.
- R7: For a read or a write, `burst_lo` equals `log_addr[2:0]`, and `sda10` equals `a10_flag`, which requests auto-precharge.
- R8: For a precharge (2'b11), `addr_bus` carries only the bank bits, at `[q+1:q]`. `burst_lo` is zero, and `sda10` equals `a10_flag`, which requests all banks.
- R9: `sda10` and `burst_lo` keep the same value through the address and data phases. `addr_bus` is zero in the data phase. All outputs are zero while idle.
- R10: The effective bank position q is `cfg_bank_pos` when that value lies between 13 and 22. Values above 22 give 22, and values below 13 give 13.
- R11: Changing `cfg_bank_pos`, `log_addr`, `cmd_kind` or `a10_flag` during an access does not alter the outputs of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_kind | input | 2 | 00 activate, 01 read, 10 write, 11 precharge |
| a10_flag | input | 1 | Auto-precharge (read/write) or all-banks (precharge) |
| log_addr | input | 24 | Logical address: column [8:0], bank [10:9], row [23:11] |
| cfg_bank_pos | input | 5 | Requested lowest pin of the bank-select field |
| busy | output | 1 | Access in progress |
| ale | output | 1 | Address-latch strobe, high in the address phase |
| addr_bus | output | 24 | Multiplexed address bus, valid while `ale` is high |
| sda10 | output | 1 | Dedicated device A10 |
| burst_lo | output | 3 | Unlatched device address bits 2..0 |

## Verification
Several properties are checked on every cycle:
- the two-phase framing of an access;
- that a request arriving while busy is dropped;
- that A10 and the low burst bits are held across both phases;
- the zero bus in the data and idle phases;
- the row and column placement on the low pins.

The exact bank-bit placement for each requested position, including the clamping of out-of-range settings, is shown only by the bench sweep. The same applies to the full read/write bus word and to the immunity of a registered access to configuration changes made during it. The sweep covers every bank-position value, every command kind, both flag values and several address patterns.

// File: rtl/sdram_amux_pkg.sv
// Shared types for the SDRAM address multiplexer.
// Assumes a two-bit command code as listed in the brief.
package sdram_amux_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10,
        CMD_PRE = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ADDR = 2'b01,
        PH_DATA = 2'b10
    } phase_e;

endpackage

// File: rtl/sdram_amux_pos_clamp.sv
// Limits the requested bank-select pin position to the legal window.
// The lowest legal position sits just above the row field, so the row and
// bank never overlap. The highest keeps the whole field inside the bus.
// Purely combinational.
module sdram_amux_pos_clamp #(
    parameter int ADDR_W = 24,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int POS_W  = $clog2(ADDR_W)
) (
    input  logic [POS_W-1:0] pos_req,
    output logic [POS_W-1:0] pos_eff
);
    localparam logic [POS_W-1:0] POS_MIN = POS_W'(ROW_W);
    localparam logic [POS_W-1:0] POS_MAX = POS_W'(ADDR_W - BANK_W);

    // Saturate the request at both ends of the window.
    always_comb begin
        if (pos_req > POS_MAX) begin
            pos_eff = POS_MAX;
        end else if (pos_req < POS_MIN) begin
            pos_eff = POS_MIN;
        end else begin
            pos_eff = pos_req;
        end
    end
endmodule

// File: rtl/sdram_amux_format.sv
// Builds the device pin values for one command from the logical address.
// Assumes the logical layout {row, bank, column} from high bits to low,
// and a legal bank position supplied by the clamp. Combinational.
module sdram_amux_format
    import sdram_amux_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int COL_W   = 9,
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 13,
    parameter int BURST_W = 3,
    parameter int A10_BIT = 10,
    parameter int POS_W   = $clog2(ADDR_W)
) (
    input  logic [ADDR_W-1:0]  log_addr,
    input  cmd_e               kind,
    input  logic               a10_flag,
    input  logic [POS_W-1:0]   bank_pos,
    output logic [ADDR_W-1:0]  pin_addr,
    output logic               pin_a10,
    output logic [BURST_W-1:0] pin_burst
);
    localparam int ROW_LSB = COL_W + BANK_W;

    logic [COL_W-1:0]  col;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [ADDR_W-1:0] bank_mask;
    logic [ADDR_W-1:0] bank_pins;
    logic [ADDR_W-1:0] act_word;
    logic [ADDR_W-1:0] rw_word;

    assign col  = log_addr[COL_W-1:0];
    assign bank = log_addr[COL_W +: BANK_W];
    assign row  = log_addr[ROW_LSB +: ROW_W];

    // Bank field moved to its programmed pin position.
    assign bank_mask = ADDR_W'({BANK_W{1'b1}}) << bank_pos;
    assign bank_pins = ADDR_W'(bank) << bank_pos;

    // Activate places the row on the lowest pins, with the bank above it.
    assign act_word = (ADDR_W'(row) & ~bank_mask) | bank_pins;

    // Read/write keeps the full address, with the bank overlaid.
    assign rw_word = (log_addr & ~bank_mask) | bank_pins;

    // Pick the bus word, the A10 value and the unlatched low bits per command.
    always_comb begin
        unique case (kind)
            CMD_ACT: begin
                pin_addr  = act_word;
                pin_a10   = row[A10_BIT];
                pin_burst = row[BURST_W-1:0];
            end
            CMD_RD, CMD_WR: begin
                pin_addr  = rw_word;
                pin_a10   = a10_flag;
                pin_burst = col[BURST_W-1:0];
            end
            default: begin
                pin_addr  = bank_pins;
                pin_a10   = a10_flag;
                pin_burst = '0;
            end
        endcase
    end
endmodule

// File: rtl/sdram_amux_seq.sv
// Two-phase access sequencer.
// It registers the formatted pins when a command is accepted in idle. It
// presents the bus with the latch strobe for one cycle, then holds A10 and
// the burst bits through the data phase. Requests made while busy are
// dropped.
module sdram_amux_seq
    import sdram_amux_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int BURST_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  pin_addr,
    input  logic               pin_a10,
    input  logic [BURST_W-1:0] pin_burst,
    output logic               busy,
    output logic               ale,
    output logic [ADDR_W-1:0]  addr_bus,
    output logic               sda10,
    output logic [BURST_W-1:0] burst_lo
);
    phase_e               phase;
    logic [ADDR_W-1:0]    addr_q;
    logic                 a10_q;
    logic [BURST_W-1:0]   burst_q;

    // Phase progression and capture of the pin values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            addr_q  <= '0;
            a10_q   <= 1'b0;
            burst_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_ADDR;
                        addr_q  <= pin_addr;
                        a10_q   <= pin_a10;
                        burst_q <= pin_burst;
                    end
                end
                PH_ADDR: begin
                    phase  <= PH_DATA;
                    addr_q <= '0;
                end
                PH_DATA: begin
                    phase   <= PH_IDLE;
                    a10_q   <= 1'b0;
                    burst_q <= '0;
                end
                default: begin
                    phase   <= PH_IDLE;
                    addr_q  <= '0;
                    a10_q   <= 1'b0;
                    burst_q <= '0;
                end
            endcase
        end
    end

    // Status and pin outputs taken straight from state.
    assign busy     = (phase != PH_IDLE);
    assign ale      = (phase == PH_ADDR);
    assign addr_bus = addr_q;
    assign sda10    = a10_q;
    assign burst_lo = burst_q;
endmodule

// File: rtl/sdram_amux.sv
// Top of the SDRAM row/column address multiplexer.
// Accepts a command in idle, maps the logical address for that command
// using the bank position as seen at acceptance, and runs a two-phase
// access on a shared address/data bus.
module sdram_amux
    import sdram_amux_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int COL_W   = 9,
    parameter int BANK_W  = 2,
    parameter int BURST_W = 3,
    parameter int A10_BIT = 10,
    parameter int POS_W   = $clog2(ADDR_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_kind,
    input  logic               a10_flag,
    input  logic [ADDR_W-1:0]  log_addr,
    input  logic [POS_W-1:0]   cfg_bank_pos,
    output logic               busy,
    output logic               ale,
    output logic [ADDR_W-1:0]  addr_bus,
    output logic               sda10,
    output logic [BURST_W-1:0] burst_lo
);
    localparam int ROW_W = ADDR_W - COL_W - BANK_W;

    logic [POS_W-1:0]   pos_eff;
    logic [ADDR_W-1:0]  pin_addr;
    logic               pin_a10;
    logic [BURST_W-1:0] pin_burst;
    logic               start;

    // A request counts only when no access is running.
    assign start = cmd_valid && !busy;

    sdram_amux_pos_clamp #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .POS_W(POS_W)
    ) u_clamp (
        .pos_req(cfg_bank_pos),
        .pos_eff(pos_eff)
    );

    sdram_amux_format #(
        .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .BURST_W(BURST_W), .A10_BIT(A10_BIT), .POS_W(POS_W)
    ) u_fmt (
        .log_addr (log_addr),
        .kind     (cmd_e'(cmd_kind)),
        .a10_flag (a10_flag),
        .bank_pos (pos_eff),
        .pin_addr (pin_addr),
        .pin_a10  (pin_a10),
        .pin_burst(pin_burst)
    );

    sdram_amux_seq #(
        .ADDR_W(ADDR_W), .BURST_W(BURST_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .pin_addr (pin_addr),
        .pin_a10  (pin_a10),
        .pin_burst(pin_burst),
        .busy     (busy),
        .ale      (ale),
        .addr_bus (addr_bus),
        .sda10    (sda10),
        .burst_lo (burst_lo)
    );
endmodule

// File: rtl/sdram_amux_chk.sv
// Property checker for the SDRAM address multiplexer, bound to the top.
// It observes only the top-level ports.
module sdram_amux_chk #(
    parameter int ADDR_W  = 24,
    parameter int COL_W   = 9,
    parameter int BANK_W  = 2,
    parameter int BURST_W = 3,
    parameter int A10_BIT = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [1:0]         cmd_kind,
    input logic               a10_flag,
    input logic [ADDR_W-1:0]  log_addr,
    input logic               busy,
    input logic               ale,
    input logic [ADDR_W-1:0]  addr_bus,
    input logic               sda10,
    input logic [BURST_W-1:0] burst_lo
);
    localparam int ROW_W   = ADDR_W - COL_W - BANK_W;
    localparam int ROW_LSB = COL_W + BANK_W;

    logic accept;
    assign accept = cmd_valid && !busy;

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ale && busy));

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && busy));

    p_no_extend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ale) |=> !busy);

    p_rise_with_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ale);

    p_act_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_kind == 2'b00) |=>
            (addr_bus[ROW_W-1:0] == $past(log_addr[ROW_LSB +: ROW_W])));

    p_act_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_kind == 2'b00) |=>
            ($countones(addr_bus) ==
             $countones($past(log_addr[ROW_LSB +: ROW_W])) +
             $countones($past(log_addr[COL_W +: BANK_W]))));

    p_act_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_kind == 2'b00) |=>
            (sda10 == $past(log_addr[ROW_LSB + A10_BIT]) &&
             burst_lo == $past(log_addr[ROW_LSB +: BURST_W])));

    p_rw_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cmd_kind == 2'b01 || cmd_kind == 2'b10)) |=>
            (addr_bus[COL_W-1:0] == $past(log_addr[COL_W-1:0])));

    p_rw_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cmd_kind == 2'b01 || cmd_kind == 2'b10)) |=>
            (sda10 == $past(a10_flag) &&
             burst_lo == $past(log_addr[BURST_W-1:0])));

    p_pre_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_kind == 2'b11) |=>
            (sda10 == $past(a10_flag) && burst_lo == '0 &&
             $countones(addr_bus) <= BANK_W));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> ($stable(sda10) && $stable(burst_lo)));

    p_data_bus_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ale) |-> (addr_bus == '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ale && addr_bus == '0 && !sda10 && burst_lo == '0));
endmodule

bind sdram_amux sdram_amux_chk #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W),
    .BURST_W(BURST_W), .A10_BIT(A10_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_kind (cmd_kind),
    .a10_flag (a10_flag),
    .log_addr (log_addr),
    .busy     (busy),
    .ale      (ale),
    .addr_bus (addr_bus),
    .sda10    (sda10),
    .burst_lo (burst_lo)
);

// File: tb/sdram_amux_test.sv
`timescale 1ns/1ps
// Sweep bench: every bank-position code, every command kind, both flag
// values and three address patterns, with expected pins computed here.
module sdram_amux_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic        a10_flag;
    logic [23:0] log_addr;
    logic [4:0]  cfg_bank_pos;
    logic        busy;
    logic        ale;
    logic [23:0] addr_bus;
    logic        sda10;
    logic [2:0]  burst_lo;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    sdram_amux uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .a10_flag(a10_flag), .log_addr(log_addr), .cfg_bank_pos(cfg_bank_pos),
        .busy(busy), .ale(ale), .addr_bus(addr_bus), .sda10(sda10),
        .burst_lo(burst_lo)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int eff_pos(input int p);
        if (p < 13) return 13;
        if (p > 22) return 22;
        return p;
    endfunction

    function automatic logic [23:0] exp_bus(input int k, input logic [23:0] a,
                                            input int p);
        logic [23:0] e;
        int q;
        q = eff_pos(p);
        case (k)
            0:       e = {11'd0, a[23:11]};
            1, 2:    e = a;
            default: e = '0;
        endcase
        e[q +: 2] = a[10:9];
        return e;
    endfunction

    task automatic run_cmd(input int k, input int f, input logic [23:0] a,
                           input int p);
        logic [23:0] eb;
        logic        ea;
        logic [2:0]  eu;
        string       rb;
        eb = exp_bus(k, a, p);
        ea = (k == 0) ? a[21] : f[0];
        eu = (k == 0) ? a[13:11] : ((k == 3) ? 3'd0 : a[2:0]);
        rb = (k == 0) ? "R4" : ((k == 3) ? "R8" : "R6");
        cmd_valid    = 1'b1;
        cmd_kind     = k[1:0];
        a10_flag     = f[0];
        log_addr     = a;
        cfg_bank_pos = p[4:0];
        @(negedge clk);
        // Address phase.
        check("R2", "ale", {31'd0, ale}, 32'd1);
        check("R2", "busy", {31'd0, busy}, 32'd1);
        check(rb, "addr_bus (R10 clamp)", {8'd0, addr_bus}, {8'd0, eb});
        check((k == 0) ? "R5" : ((k == 3) ? "R8" : "R7"), "sda10",
              {31'd0, sda10}, {31'd0, ea});
        check((k == 0) ? "R5" : ((k == 3) ? "R8" : "R7"), "burst_lo",
              {29'd0, burst_lo}, {29'd0, eu});
        // Disturb every input while busy (R3, R11).
        cmd_valid    = 1'b1;
        cmd_kind     = ~k[1:0];
        a10_flag     = ~f[0];
        log_addr     = ~a;
        cfg_bank_pos = ~p[4:0];
        #2;
        check("R11", "addr_bus after cfg change", {8'd0, addr_bus}, {8'd0, eb});
        @(negedge clk);
        // Data phase.
        check("R2", "ale data", {31'd0, ale}, 32'd0);
        check("R3", "busy data", {31'd0, busy}, 32'd1);
        check("R9", "addr_bus data", {8'd0, addr_bus}, 32'd0);
        check("R9", "sda10 held", {31'd0, sda10}, {31'd0, ea});
        check("R11", "burst held", {29'd0, burst_lo}, {29'd0, eu});
        cmd_valid = 1'b0;
        @(negedge clk);
        // Idle again: the request made while busy was dropped.
        check("R3", "busy idle", {31'd0, busy}, 32'd0);
        check("R9", "idle outputs", {7'd0, ale, addr_bus},
              32'd0);
        check("R9", "idle pins", {28'd0, sda10, burst_lo}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] a;
        rst_n        = 1'b0;
        cmd_valid    = 1'b1;
        cmd_kind     = 2'b01;
        a10_flag     = 1'b1;
        log_addr     = 24'hFFFFFF;
        cfg_bank_pos = 5'd15;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset busy/ale", {30'd0, busy, ale}, 32'd0);
        check("R1", "reset bus", {8'd0, addr_bus}, 32'd0);
        check("R1", "reset pins", {28'd0, sda10, burst_lo}, 32'd0);
        cmd_valid = 1'b0;
        rst_n     = 1'b1;
        @(negedge clk);
        check("R1", "after reset", {7'd0, busy, ale, addr_bus[22:0]}, 32'd0);
        for (int p = 0; p < 32; p++) begin
            for (int k = 0; k < 4; k++) begin
                for (int f = 0; f < 2; f++) begin
                    for (int n = 0; n < 3; n++) begin
                        case (n)
                            0:       a = 24'hFFFFFF;
                            1:       a = 24'h5A5A5A ^ (24'(p) * 24'h001357);
                            default: a = 24'(p) * 24'h0BEEF1 + 24'(k) * 24'h31
                                         + 24'(f);
                        endcase
                        run_cmd(k, f, a, p);
                    end
                end
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule